// File: doc/BRIEF.md
# SPI Master Word Shifter

This block is the data path of an SPI master. Software-side logic writes 8-bit words into a small transmit queue. Whenever the engine is enabled and that queue is not empty, the engine takes the next word and shifts it out on the serial data output, most significant bit first. In the same word it captures eight bits from the serial data input, and the captured word goes into a receive queue from which the host pops it.

The engine reads its settings from static configuration inputs:

- clock polarity and clock phase, which together give the four usual SPI modes;
- a 3-bit exponent that sets the serial clock rate as a power-of-two fraction of the core clock;
- a 4-bit select field, where the lowest zero bit picks one of three active-low slave selects;
- an idle-gap count that holds the bus quiet between consecutive words;
- an enable bit.

Configuration is expected to change only while the engine is disabled. The select lines follow the select field alone, so a slave stays selected across any number of words until the field is set back to all ones.

Top module: `spi_word_engine`

## Requirements
- R1: After reset, `sclk` is 0, every `ss_n` line is 1, `busy` is 0 and `rx_empty` is 1.
- R2: Each word is 8 bits, sent MSB first on `mosi`. A slave sampling on the correct edges receives exactly the word written to `tx_data`, in all four combinations of `cfg_cpol` and `cfg_cpha`.
- R3: While no word is in flight, `sclk` rests at `cfg_cpol`. With `cfg_cpha`=0, the first bit is on `mosi` before the first `sclk` edge, and both sides sample on leading edges. With `cfg_cpha`=1, data changes on leading edges and is sampled on trailing edges.
- R4: Within a word, every `sclk` half period lasts 2^`cfg_baud` core clock cycles for `cfg_baud` from 1 to 7 (divide-by-4 to divide-by-256).
- R5: `cfg_baud`=0 behaves exactly like `cfg_baud`=1 (half period of 2 cycles).
- R6: `ss_n[k]` is 0 only when bit k is the lowest zero bit of `cfg_sel`, for k = 0, 1, 2. A `cfg_sel` whose lowest zero bit is bit 3, or that has no zero bit (1111), drives every `ss_n` line high. At most one line is low. `ss_n` follows `cfg_sel` one cycle later.
- R7: `ss_n` does not change during or between back-to-back words while `cfg_sel` is held.
- R8: From the last `sclk` edge of one word to the first `sclk` edge of the next queued word there are 2^b + 2 + `cfg_gap` core clock cycles, where b is the effective baud exponent.
- R9: While `cfg_enable` is 0, queued words are not shifted and `sclk` does not toggle. Once it is 1 and a word is queued, `busy` rises at the next clock edge with no other start command.
- R10: Clearing `cfg_enable` mid-word aborts the word at the next edge. `busy` goes to 0, `sclk` returns to `cfg_cpol`, and no word enters the receive queue.
- R11: Each completed word puts the 8 bits sampled from `miso` (first sampled bit as MSB) into the receive queue. Words come out on `rx_data`/`rx_rd` in completion order.
- R12: The transmit queue holds `TX_DEPTH` words. `tx_full` is 1 when it is full, and a `tx_wr` while full is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Engine run enable |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_baud | input | BAUD_W | Clock exponent, half period 2^max(value,1) cycles |
| cfg_sel | input | NSS+1 | Slave select field, lowest zero bit selects |
| cfg_gap | input | GAP_W | Extra idle cycles between words |
| tx_wr | input | 1 | Push `tx_data` into the transmit queue |
| tx_data | input | 8 | Word to send |
| tx_full | output | 1 | Transmit queue full |
| rx_rd | input | 1 | Pop the head of the receive queue |
| rx_data | output | 8 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | NSS | Active-low slave selects |
| miso | input | 1 | Serial data in |
| busy | output | 1 | A word, its completion or its gap is in progress |

## Verification
The hardest condition to reach from the ports is an abort in the middle of a word. To get there, the stimulus sets a slow clock exponent so a word spans many core cycles. It then clears the enable about thirty cycles after the start, which lands between serial clock edges. It then confirms that the clock settles at its idle level and that the receive queue stays empty.

The inter-word gap is also tricky, because it can only be seen as a run of quiet cycles. A slave model in the bench timestamps every `sclk` transition. The stimulus queues two words before enabling, so the gap interval shows up as the sixteenth edge-to-edge distance in the log.

// File: rtl/spiw_pkg.sv
package spiw_pkg;
   localparam int WORD_W  = 8;
   localparam int EDGE_N  = 2 * WORD_W;
   localparam int EDGE_W  = $clog2(EDGE_N);

   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_SHIFT = 2'd1,
      ENG_FIN   = 2'd2,
      ENG_GAP   = 2'd3
   } eng_state_t;
endpackage

// File: rtl/spiw_fifo.sv
module spiw_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         rd,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = AW + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spiw_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] cnt;
   logic          wr_ok, rd_ok;

   assign full  = (cnt == CW'(DEPTH));
   assign empty = (cnt == '0);
   assign wr_ok = wr && !full;
   assign rd_ok = rd && !empty;
   assign rdata = mem[rptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (wr_ok) wptr <= wptr + 1'b1;
         if (rd_ok) rptr <= rptr + 1'b1;
         case ({wr_ok, rd_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wptr] <= wdata;
   end
endmodule

// File: rtl/spiw_baud.sv
module spiw_baud #(
   parameter int BAUD_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [BAUD_W-1:0] field,
   output logic              tick
);
   localparam int CNT_W = (1 << BAUD_W);

   if (BAUD_W < 1 || BAUD_W > 4) begin : g_bad_baud
      $error("spiw_baud: BAUD_W must be 1..4");
   end

   logic [BAUD_W-1:0] eff;
   logic [CNT_W-1:0]  limit;
   logic [CNT_W-1:0]  cnt;

   assign eff   = (field == '0) ? BAUD_W'(1) : field;
   assign limit = (CNT_W'(1) << eff) - CNT_W'(1);
   assign tick  = run && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run || tick)   cnt <= '0;
      else                     cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/spiw_sel_decode.sv
module spiw_sel_decode #(
   parameter int NSS = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NSS:0]   sel,
   output logic [NSS-1:0] ss_n
);
   if (NSS < 1 || NSS > 8) begin : g_bad_nss
      $error("spiw_sel_decode: NSS must be 1..8");
   end

   logic [NSS:0]   ones_below;
   logic [NSS-1:0] hit;

   assign ones_below[0] = 1'b1;

   for (genvar k = 0; k < NSS; k++) begin : g_slot
      assign hit[k]          = ones_below[k] & ~sel[k];
      assign ones_below[k+1] = ones_below[k] & sel[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ss_n <= '1;
      else        ss_n <= ~hit;
   end
endmodule

// File: rtl/spiw_engine.sv
module spiw_engine
   import spiw_pkg::*;
#(
   parameter int GAP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              cpol,
   input  logic              cpha,
   input  logic [GAP_W-1:0]  gap,
   input  logic              tx_avail,
   input  logic [WORD_W-1:0] tx_word,
   output logic              tx_pop,
   input  logic              tick,
   input  logic              miso,
   output logic              sclk,
   output logic              mosi,
   output logic              rx_push,
   output logic [WORD_W-1:0] rx_word,
   output logic              busy,
   output logic              run
);
   eng_state_t        state;
   logic [WORD_W-1:0] txsh, rxsh, rx_next;
   logic [EDGE_W-1:0] edges;
   logic [GAP_W-1:0]  gcnt;
   logic              leading, last_edge;

   assign rx_next   = {rxsh[WORD_W-2:0], miso};
   assign leading   = ~edges[0];
   assign last_edge = (edges == EDGE_W'(EDGE_N - 1));
   assign tx_pop    = enable && (state == ENG_IDLE) && tx_avail;
   assign rx_push   = enable && (state == ENG_FIN);
   assign rx_word   = rxsh;
   assign busy      = (state != ENG_IDLE);
   assign run       = enable && (state == ENG_SHIFT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ENG_IDLE;
         sclk  <= 1'b0;
         mosi  <= 1'b0;
         txsh  <= '0;
         rxsh  <= '0;
         edges <= '0;
         gcnt  <= '0;
      end else if (!enable) begin
         state <= ENG_IDLE;
         sclk  <= cpol;
         edges <= '0;
      end else begin
         case (state)
            ENG_IDLE: begin
               sclk  <= cpol;
               edges <= '0;
               if (tx_avail) begin
                  state <= ENG_SHIFT;
                  if (!cpha) begin
                     mosi <= tx_word[WORD_W-1];
                     txsh <= tx_word << 1;
                  end else begin
                     txsh <= tx_word;
                  end
               end
            end
            ENG_SHIFT: begin
               if (tick) begin
                  sclk  <= ~sclk;
                  edges <= edges + 1'b1;
                  if (leading) begin
                     if (cpha) begin
                        mosi <= txsh[WORD_W-1];
                        txsh <= txsh << 1;
                     end else begin
                        rxsh <= rx_next;
                     end
                  end else begin
                     if (cpha) begin
                        rxsh <= rx_next;
                     end else if (!last_edge) begin
                        mosi <= txsh[WORD_W-1];
                        txsh <= txsh << 1;
                     end
                  end
                  if (last_edge) state <= ENG_FIN;
               end
            end
            ENG_FIN: begin
               gcnt <= '0;
               if (gap == '0) state <= ENG_IDLE;
               else           state <= ENG_GAP;
            end
            ENG_GAP: begin
               if (gcnt == gap - 1'b1) state <= ENG_IDLE;
               else                    gcnt  <= gcnt + 1'b1;
            end
            default: state <= ENG_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine
   import spiw_pkg::*;
#(
   parameter int NSS      = 3,
   parameter int BAUD_W   = 3,
   parameter int GAP_W    = 8,
   parameter int TX_DEPTH = 8,
   parameter int RX_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic [BAUD_W-1:0] cfg_baud,
   input  logic [NSS:0]      cfg_sel,
   input  logic [GAP_W-1:0]  cfg_gap,
   input  logic              tx_wr,
   input  logic [7:0]        tx_data,
   output logic              tx_full,
   input  logic              rx_rd,
   output logic [7:0]        rx_data,
   output logic              rx_empty,
   output logic              sclk,
   output logic              mosi,
   output logic [NSS-1:0]    ss_n,
   input  logic              miso,
   output logic              busy
);
   if (GAP_W < 1) begin : g_bad_gap
      $error("spi_word_engine: GAP_W must be at least 1");
   end

   logic              tx_empty, tx_pop, tick, run, rx_push;
   logic [WORD_W-1:0] tx_head, rx_word;

   spiw_fifo #(.W(WORD_W), .DEPTH(TX_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .wr(tx_wr), .wdata(tx_data),
      .rd(tx_pop), .rdata(tx_head),
      .full(tx_full), .empty(tx_empty)
   );

   spiw_baud #(.BAUD_W(BAUD_W)) u_baud (
      .clk(clk), .rst_n(rst_n),
      .run(run), .field(cfg_baud), .tick(tick)
   );

   spiw_engine #(.GAP_W(GAP_W)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .enable(cfg_enable), .cpol(cfg_cpol), .cpha(cfg_cpha), .gap(cfg_gap),
      .tx_avail(~tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
      .tick(tick), .miso(miso),
      .sclk(sclk), .mosi(mosi),
      .rx_push(rx_push), .rx_word(rx_word),
      .busy(busy), .run(run)
   );

   logic rx_full_unused;

   spiw_fifo #(.W(WORD_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .wr(rx_push), .wdata(rx_word),
      .rd(rx_rd), .rdata(rx_data),
      .full(rx_full_unused), .empty(rx_empty)
   );

   spiw_sel_decode #(.NSS(NSS)) u_sel (
      .clk(clk), .rst_n(rst_n),
      .sel(cfg_sel), .ss_n(ss_n)
   );
endmodule

// File: rtl/spi_word_engine_chk.sv
module spi_word_engine_chk #(
   parameter int NSS = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           cfg_enable,
   input logic           cfg_cpol,
   input logic [NSS:0]   cfg_sel,
   input logic           sclk,
   input logic [NSS-1:0] ss_n,
   input logic           busy
);
   logic [1:0] arm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         arm <= '0;
      else if (!arm[1])   arm <= arm + 1'b1;
   end

   AST_SS_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~ss_n) <= 1); // R6

   AST_SS_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !arm[1])
      $stable(cfg_sel) |=> $stable(ss_n)); // R7

   AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n || !arm[1])
      !busy |=> (sclk == $past(cfg_cpol))); // R3

   AST_STOP_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable |=> !busy); // R10

   AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n || !arm[1])
      $rose(busy) |-> $past(cfg_enable)); // R9
endmodule

bind spi_word_engine spi_word_engine_chk #(.NSS(NSS)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_cpol(cfg_cpol),
   .cfg_sel(cfg_sel), .sclk(sclk), .ss_n(ss_n), .busy(busy)
);

// File: tb/spi_word_engine_test.sv
module spi_word_engine_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_enable = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
   logic [2:0] cfg_baud = 3'd1;
   logic [3:0] cfg_sel = 4'hF;
   logic [7:0] cfg_gap = 8'd0;
   logic       tx_wr = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       tx_full, rx_rd = 1'b0, rx_empty, sclk, mosi, busy;
   logic [7:0] rx_data;
   logic [2:0] ss_n;
   logic       miso = 1'b0;

   int n_tests = 0, n_fail = 0;

   spi_word_engine #(.TX_DEPTH(4)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_cpol(cfg_cpol),
      .cfg_cpha(cfg_cpha), .cfg_baud(cfg_baud), .cfg_sel(cfg_sel), .cfg_gap(cfg_gap),
      .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full), .rx_rd(rx_rd),
      .rx_data(rx_data), .rx_empty(rx_empty), .sclk(sclk), .mosi(mosi),
      .ss_n(ss_n), .miso(miso), .busy(busy)
   );

   always #10 clk = ~clk;

   // slave model, acting at falling core clock edges
   int         cyc = 0, last_cyc = 0, n_edges = 0, n_iv = 0, bitcnt = 0, ncap = 0;
   int         intv [0:63];
   logic [7:0] cap [0:7];
   logic [7:0] swords [0:7];
   logic [7:0] sh_out = 8'h00, s_rx = 8'h00;
   logic       prev_sclk = 1'b0;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (rst_n && sclk !== prev_sclk) begin
         if (n_edges > 0 && n_iv < 64) begin
            intv[n_iv] = cyc - last_cyc;
            n_iv = n_iv + 1;
         end
         last_cyc = cyc;
         n_edges  = n_edges + 1;
         if (sclk != cfg_cpol) begin
            if (cfg_cpha) begin miso = sh_out[7]; sh_out = sh_out << 1; end
            else s_rx = {s_rx[6:0], mosi};
         end else begin
            if (cfg_cpha) s_rx = {s_rx[6:0], mosi};
            else begin sh_out = sh_out << 1; miso = sh_out[7]; end
            bitcnt = bitcnt + 1;
            if (bitcnt == 8) begin
               if (ncap < 8) cap[ncap] = s_rx;
               ncap   = ncap + 1;
               bitcnt = 0;
               sh_out = swords[ncap % 8];
               if (!cfg_cpha) miso = sh_out[7];
            end
         end
      end
      prev_sclk = sclk;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick_n(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic set_cfg(input logic en, input logic pol, input logic pha,
                          input logic [2:0] bd, input logic [3:0] sl, input logic [7:0] gp);
      @(posedge clk); #1;
      cfg_enable = en; cfg_cpol = pol; cfg_cpha = pha;
      cfg_baud = bd; cfg_sel = sl; cfg_gap = gp;
      tick_n(3);
   endtask

   task automatic mon_clear();
      n_edges = 0; n_iv = 0; bitcnt = 0; ncap = 0;
      sh_out = swords[0];
      miso = cfg_cpha ? 1'b0 : sh_out[7];
      prev_sclk = sclk;
   endtask

   task automatic push(input logic [7:0] w);
      @(posedge clk); #1;
      tx_wr = 1'b1; tx_data = w;
      @(posedge clk); #1;
      tx_wr = 1'b0;
   endtask

   task automatic pop(output logic [7:0] w);
      w = rx_data;
      @(posedge clk); #1;
      rx_rd = 1'b1;
      @(posedge clk); #1;
      rx_rd = 1'b0;
   endtask

   task automatic wait_words(input int n);
      for (int i = 0; i < 20000; i++) begin
         if (ncap >= n && !busy) break;
         tick_n(1);
      end
      tick_n(4);
   endtask

   task automatic t_reset();
      chk("R1 sclk", sclk, 0);
      chk("R1 ss_n", ss_n, 3'b111);
      chk("R1 busy", busy, 0);
      chk("R1 rx_empty", rx_empty, 1);
   endtask

   task automatic t_modes();
      logic [7:0] w;
      for (int m = 0; m < 4; m++) begin
         set_cfg(1'b0, m[1], m[0], 3'd1, 4'b1110, 8'd0);
         chk($sformatf("R3 idle level mode %0d", m), sclk, m[1]);
         swords[0] = 8'h3C ^ 8'(m * 17);
         mon_clear();
         push(8'hA5 ^ 8'(m * 9));
         set_cfg(1'b1, m[1], m[0], 3'd1, 4'b1110, 8'd0);
         wait_words(1);
         chk($sformatf("R2 R3 mosi word mode %0d", m), cap[0], 8'hA5 ^ 8'(m * 9));
         chk($sformatf("R11 rx word mode %0d", m), rx_data, swords[0]);
         pop(w);
         chk($sformatf("R3 rest level mode %0d", m), sclk, m[1]);
         set_cfg(1'b0, m[1], m[0], 3'd1, 4'b1110, 8'd0);
      end
   endtask

   task automatic t_baud();
      int   half;
      logic ok;
      logic [7:0] w;
      for (int f = 0; f < 4; f++) begin
         set_cfg(1'b0, 1'b0, 1'b0, 3'(f), 4'b1111, 8'd0);
         swords[0] = 8'h81;
         mon_clear();
         push(8'h5A);
         set_cfg(1'b1, 1'b0, 1'b0, 3'(f), 4'b1111, 8'd0);
         wait_words(1);
         half = 1 << ((f == 0) ? 1 : f);
         ok = (n_iv == 15);
         for (int i = 0; i < 15; i++) if (intv[i] != half) ok = 1'b0;
         chk((f == 0) ? "R5 field0 half period" : "R4 half period", ok ? half : intv[0], half);
         pop(w);
         set_cfg(1'b0, 1'b0, 1'b0, 3'(f), 4'b1111, 8'd0);
      end
   endtask

   task automatic t_sel();
      logic [3:0] pat [6] = '{4'b1110, 4'b1101, 4'b1011, 4'b0111, 4'b1111, 4'b0101};
      logic [2:0] exp [6] = '{3'b110, 3'b101, 3'b011, 3'b111, 3'b111, 3'b101};
      for (int i = 0; i < 6; i++) begin
         set_cfg(1'b0, 1'b0, 1'b0, 3'd1, pat[i], 8'd0);
         chk($sformatf("R6 select %b", pat[i]), ss_n, exp[i]);
      end
   endtask

   task automatic t_gap(input logic [7:0] g);
      logic [7:0] w;
      logic       ss_moved;
      set_cfg(1'b0, 1'b0, 1'b1, 3'd1, 4'b1101, g);
      swords[0] = 8'hC3; swords[1] = 8'h17;
      mon_clear();
      push(8'h96); push(8'h4E);
      set_cfg(1'b1, 1'b0, 1'b1, 3'd1, 4'b1101, g);
      ss_moved = 1'b0;
      for (int i = 0; i < 400; i++) begin
         if (ss_n !== 3'b101) ss_moved = 1'b1;
         if (ncap >= 2 && !busy) break;
         tick_n(1);
      end
      tick_n(4);
      chk("R8 inter-word gap", intv[15], 2 + 2 + g);
      chk("R7 select held", ss_moved, 0);
      chk("R2 word order first", cap[0], 8'h96);
      chk("R2 word order second", cap[1], 8'h4E);
      pop(w); chk("R11 rx first", w, 8'hC3);
      pop(w); chk("R11 rx second", w, 8'h17);
      chk("R11 rx drained", rx_empty, 1);
      set_cfg(1'b0, 1'b0, 1'b1, 3'd1, 4'b1111, 8'd0);
   endtask

   task automatic t_autostart();
      logic [7:0] w;
      set_cfg(1'b0, 1'b0, 1'b0, 3'd1, 4'b1110, 8'd0);
      swords[0] = 8'h00;
      mon_clear();
      push(8'h11);
      tick_n(50);
      chk("R9 no edges while disabled", n_edges, 0);
      chk("R9 idle while disabled", busy, 0);
      @(posedge clk); #1;
      cfg_enable = 1'b1;
      tick_n(1);
      chk("R9 busy after enable", busy, 1);
      wait_words(1);
      chk("R9 word sent", cap[0], 8'h11);
      pop(w);
      set_cfg(1'b0, 1'b0, 1'b0, 3'd1, 4'b1110, 8'd0);
   endtask

   task automatic t_abort();
      set_cfg(1'b0, 1'b1, 1'b0, 3'd3, 4'b1110, 8'd0);
      swords[0] = 8'hFF;
      mon_clear();
      push(8'hF0);
      @(posedge clk); #1;
      cfg_enable = 1'b1;
      tick_n(30);
      cfg_enable = 1'b0;
      tick_n(1);
      chk("R10 busy cleared", busy, 0);
      chk("R10 sclk idle", sclk, 1);
      tick_n(40);
      chk("R10 sclk stays idle", sclk, 1);
      chk("R10 no rx word", rx_empty, 1);
   endtask

   task automatic t_txfull();
      logic [7:0] w;
      set_cfg(1'b0, 1'b0, 1'b0, 3'd1, 4'b1110, 8'd0);
      for (int i = 0; i < 8; i++) swords[i] = 8'(8'h20 + i);
      mon_clear();
      for (int i = 0; i < 5; i++) push(8'(8'h70 + i));
      chk("R12 tx_full", tx_full, 1);
      set_cfg(1'b1, 1'b0, 1'b0, 3'd1, 4'b1110, 8'd0);
      wait_words(4);
      tick_n(80);
      chk("R12 extra write ignored", ncap, 4);
      chk("R12 last kept word", cap[3], 8'h73);
      for (int i = 0; i < 4; i++) begin
         pop(w);
         chk("R11 rx order", w, 8'(8'h20 + i));
      end
      set_cfg(1'b0, 1'b0, 1'b0, 3'd1, 4'b1111, 8'd0);
   endtask

   initial begin
      #(20 * 150000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) swords[i] = 8'h00;
      tick_n(3);
      #5;
      t_reset();
      rst_n = 1'b1;
      tick_n(3);
      t_modes();
      t_baud();
      t_sel();
      t_gap(8'd5);
      t_gap(8'd0);
      t_autostart();
      t_abort();
      t_txfull();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule